// File: doc/BRIEF.md
# PWM Timer with Programmable Top

This block is an 8-bit up-counter with three compare values. Compare value C is the top of the count. When the counter has reached C, the next count step takes it back to zero. Compare values A and B each drive one output channel. A prescaler outside the block produces a count-enable pulse, and the counter moves only on cycles where that pulse is high.

The block has two modes. In normal mode, a compare match on a channel toggles that channel's output. In PWM mode, each channel goes high when the counter restarts and goes low on its compare match. In PWM mode each channel also drives an inverted companion output, and a shared enable for those companion outputs is asserted.

Three sticky flags record overflow, match A and match B. Software clears a flag by writing 1 to its bit. A mask register selects which flags raise the interrupt request. All registers are written through a simple address/data write port.

Top module: `pwm_timer_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following are cleared: the count, all flags, the mask, both channel outputs, compare values A and B, and the mode bit. Compare value C is set to 0xFF.
- R2: On each cycle with `cnt_en` high, the count rises by one. If the count equals C, or equals 0xFF, it goes to 0x00 instead. With `cnt_en` low, the count holds.
- R3: Flag bit 0 (overflow) is set at the edge where a count step takes the counter to 0x00 from C or from 0xFF. This applies in both modes.
- R4: Flag bit 1 (match A) is set at the edge where a count step makes the count equal compare value A. Flag bit 2 (match B) is set the same way for compare value B. This applies in both modes.
- R5: In normal mode (address 0, bit 0 = 0), each match step of a channel toggles that channel's true output.
- R6: In PWM mode (address 0, bit 0 = 1), a channel's true output goes high at the step that restarts the counter and goes low at its match step. If both happen on the same step, the output goes low. A compare value above C gives a constant high output.
- R7: In PWM mode, `out_a_n` and `out_b_n` are the complements of `out_a` and `out_b`, and `inv_oe` is 1. In normal mode, both inverted outputs and `inv_oe` are 0.
- R8: Writing address 5 clears each flag whose data bit is 1 and leaves the other flags unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R9: `irq` is high when any flag bit is 1 and its mask bit is also 1. The mask is written at address 4, with the same bit order as the flags.
- R10: Addresses 1, 2 and 3 write compare values A, B and C. Every register write takes effect at the edge where `wr_en` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Prescaled count step enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | W | Register write data |
| count | output | W | Current counter value |
| flags | output | 3 | Flags: bit0 overflow, bit1 match A, bit2 match B |
| irq | output | 1 | Interrupt request |
| out_a | output | 1 | Channel A true output |
| out_a_n | output | 1 | Channel A inverted output |
| out_b | output | 1 | Channel B true output |
| out_b_n | output | 1 | Channel B inverted output |
| inv_oe | output | 1 | Enable for the inverted outputs |

## Verification
The bench lowers C below the current count. A design that compares only for equality with C then runs on to 0xFF and must still wrap there and flag an overflow; a design missing that path would skip the overflow flag. The bench puts a PWM compare value at 0 and another above C. A wrong priority between restart and match would give a one-cycle glitch at 0% duty instead of a steady level, and a wrong limit check would miss the steady high. The bench also clears a flag on the very cycle it is set, where a clear-wins design would lose the event. Finally, it confirms that the inverted outputs stay at zero in normal mode.

// File: rtl/pwm_timer_pkg.sv
// Shared definitions for the PWM timer: register addresses and flag bit positions.
package pwm_timer_pkg;
    typedef enum logic [2:0] {
        ADDR_MODE  = 3'd0,
        ADDR_CMP_A = 3'd1,
        ADDR_CMP_B = 3'd2,
        ADDR_TOP   = 3'd3,
        ADDR_MASK  = 3'd4,
        ADDR_FCLR  = 3'd5
    } reg_addr_e;

    localparam int NUM_FLAGS = 3;
    localparam int FLAG_OVF  = 0;
    localparam int FLAG_MA   = 1;
    localparam int FLAG_MB   = 2;
endpackage

// File: rtl/pwm_timer_regs.sv
// Register file: mode, compare values, interrupt mask and sticky flags.
// Assumes writes are single-cycle strobes. Flag set events take priority over clears.
module pwm_timer_regs
    import pwm_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [W-1:0]         wr_data,
    input  logic [NUM_FLAGS-1:0] set_evt,
    output logic                 pwm_mode,
    output logic [W-1:0]         cmp_a,
    output logic [W-1:0]         cmp_b,
    output logic [W-1:0]         top,
    output logic [NUM_FLAGS-1:0] mask,
    output logic [NUM_FLAGS-1:0] flags
);
    logic [NUM_FLAGS-1:0] clr_bits;

    // Decode the write-one-to-clear bits for the flag register.
    always_comb begin
        clr_bits = '0;
        if (wr_en && wr_addr == ADDR_FCLR)
            clr_bits = wr_data[NUM_FLAGS-1:0];
    end

    // Configuration registers written by address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_mode <= 1'b0;
            cmp_a    <= '0;
            cmp_b    <= '0;
            top      <= '1;
            mask     <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_MODE:  pwm_mode <= wr_data[0];
                ADDR_CMP_A: cmp_a    <= wr_data;
                ADDR_CMP_B: cmp_b    <= wr_data;
                ADDR_TOP:   top      <= wr_data;
                ADDR_MASK:  mask     <= wr_data[NUM_FLAGS-1:0];
                default:    ;
            endcase
        end
    end

    // Sticky flags: set on events, cleared by write-one, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_bits) | set_evt;
    end

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt[FLAG_OVF] |=> flags[FLAG_OVF]);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_bits[FLAG_MA] && !set_evt[FLAG_MA]) |=> !flags[FLAG_MA]);
endmodule

// File: rtl/pwm_timer_counter.sv
// Up-counter with programmable top. It steps only when enabled and wraps to zero
// after reaching top or all-ones. Assumes top may change at any time.
module pwm_timer_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_next,
    output logic         wrap_evt
);
    logic at_end;

    // Compute the wrap condition and the next count value.
    always_comb begin
        at_end   = (cnt_q == top) || (cnt_q == {W{1'b1}});
        cnt_next = at_end ? '0 : cnt_q + 1'b1;
        wrap_evt = step && at_end;
    end

    // Count register, advanced on enabled cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (step) cnt_q <= cnt_next;
    end

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q));
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q != top && cnt_q != {W{1'b1}}) |=> cnt_q == $past(cnt_q) + 1'b1);
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> cnt_q == '0);
endmodule

// File: rtl/pwm_timer_channel.sv
// One output channel. It detects the compare match on the count step and drives
// the true output. In normal mode a match toggles the output. In PWM mode a restart
// sets the output and a match clears it, with the match taking priority.
module pwm_timer_channel #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         wrap_evt,
    input  logic         pwm_mode,
    input  logic [W-1:0] cnt_next,
    input  logic [W-1:0] cmp,
    output logic         match_evt,
    output logic         out_q
);
    // Match when the step lands the counter on the compare value.
    always_comb match_evt = step && (cnt_next == cmp);

    // Output register update per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (pwm_mode) begin
            if (match_evt)     out_q <= 1'b0;
            else if (wrap_evt) out_q <= 1'b1;
        end else if (match_evt) begin
            out_q <= ~out_q;
        end
    end

    a_r6_match_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode && match_evt) |=> !out_q);
    a_r6_restart_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode && wrap_evt && !match_evt) |=> out_q);
    a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_mode && match_evt) |=> out_q != $past(out_q));
endmodule

// File: rtl/pwm_timer_top.sv
// PWM timer top. It ties the register file, the counter and two output channels
// together, and derives the inverted outputs and the interrupt request.
// Assumes cnt_en comes from an external prescaler as a one-cycle pulse.
module pwm_timer_top
    import pwm_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cnt_en,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [W-1:0]         wr_data,
    output logic [W-1:0]         count,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 irq,
    output logic                 out_a,
    output logic                 out_a_n,
    output logic                 out_b,
    output logic                 out_b_n,
    output logic                 inv_oe
);
    localparam int NCH = 2;

    logic                 pwm_mode;
    logic [W-1:0]         cmp_a, cmp_b, top, cnt_next;
    logic [NUM_FLAGS-1:0] mask, set_evt;
    logic                 wrap_evt;
    logic [W-1:0]         cmp_v [NCH];
    logic [NCH-1:0]       match_v, out_v;

    pwm_timer_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .set_evt(set_evt), .pwm_mode(pwm_mode),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .top(top), .mask(mask), .flags(flags)
    );

    pwm_timer_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(cnt_en), .top(top),
        .cnt_q(count), .cnt_next(cnt_next), .wrap_evt(wrap_evt)
    );

    // Route the compare values to the channel array.
    always_comb begin
        cmp_v[0] = cmp_a;
        cmp_v[1] = cmp_b;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwm_timer_channel #(.W(W)) u_ch (
            .clk(clk), .rst_n(rst_n), .step(cnt_en), .wrap_evt(wrap_evt),
            .pwm_mode(pwm_mode), .cnt_next(cnt_next), .cmp(cmp_v[i]),
            .match_evt(match_v[i]), .out_q(out_v[i])
        );
    end

    // Flag events, pin outputs and the interrupt request.
    always_comb begin
        set_evt           = '0;
        set_evt[FLAG_OVF] = wrap_evt;
        set_evt[FLAG_MA]  = match_v[0];
        set_evt[FLAG_MB]  = match_v[1];
        out_a   = out_v[0];
        out_b   = out_v[1];
        inv_oe  = pwm_mode;
        out_a_n = pwm_mode & ~out_v[0];
        out_b_n = pwm_mode & ~out_v[1];
        irq     = |(flags & mask);
    end

    a_r3_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && count == top) |=> flags[FLAG_OVF]);
    a_r4_match_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && count != cmp_a && count + 1'b1 == cmp_a && count != top) |=> flags[FLAG_MA]);
    a_r7_pair: assert property (@(posedge clk) disable iff (!rst_n)
        inv_oe |-> (out_a_n != out_a) && (out_b_n != out_b));
endmodule

// File: tb/pwm_timer_top_test.sv
// Directed bench: one task per scenario, each checking its own results.
module pwm_timer_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] count;
    logic [2:0] flags;
    logic       irq, out_a, out_a_n, out_b, out_b_n, inv_oe;
    int checks = 0;
    int errors = 0;

    pwm_timer_top #(.W(8)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .count(count), .flags(flags),
        .irq(irq), .out_a(out_a), .out_a_n(out_a_n), .out_b(out_b),
        .out_b_n(out_b_n), .inv_oe(inv_oe)
    );

    always #4 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cnt_en = 1'b0;
        wr_en = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic step(int n);
        cnt_en = 1'b1;
        repeat (n) tick();
        cnt_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 count", count, 0);
        chk("R1 flags", flags, 0);
        chk("R1 irq", irq, 0);
        chk("R1 outs", {out_a, out_a_n, out_b, out_b_n, inv_oe}, 0);
        step(255);
        chk("R1 top=FF count", count, 255);
        chk("R1 top=FF no ovf", flags[0], 0);
        step(1);
        chk("R3 ovf at FF->0", flags[0], 1);
    endtask

    task automatic t_top_wrap();
        do_reset();
        wr(3'd1, 8'd9);
        wr(3'd2, 8'd9);
        wr(3'd3, 8'd4);
        step(4);
        chk("R2 count to top", count, 4);
        chk("R3 no ovf yet", flags[0], 0);
        cnt_en = 1'b0;
        repeat (5) tick();
        chk("R2 hold without enable", count, 4);
        step(1);
        chk("R2 wrap at top", count, 0);
        chk("R3 ovf at top", flags[0], 1);
    endtask

    task automatic t_top_below();
        do_reset();
        step(10);
        wr(3'd3, 8'd3);
        wr(3'd5, 8'h07);
        step(245);
        chk("R2 runs past lowered top", count, 255);
        chk("R3 no ovf before FF", flags[0], 0);
        step(1);
        chk("R2 FF wraps", count, 0);
        chk("R3 ovf from FF", flags[0], 1);
        step(3);
        chk("R2 new top honored", count, 3);
        step(1);
        chk("R2 wrap at new top", count, 0);
    endtask

    task automatic t_normal();
        do_reset();
        wr(3'd1, 8'd2);
        wr(3'd2, 8'd3);
        wr(3'd3, 8'd5);
        step(2);
        chk("R5 a toggles high", out_a, 1);
        chk("R4 match A flag", flags[1], 1);
        chk("R5 b unchanged", out_b, 0);
        step(1);
        chk("R5 b toggles high", out_b, 1);
        chk("R4 match B flag", flags[2], 1);
        chk("R7 inverted off", {out_a_n, out_b_n, inv_oe}, 0);
        step(5);
        chk("R5 a toggles low", out_a, 0);
        chk("R5 b holds", out_b, 1);
        chk("R3 ovf normal", flags[0], 1);
    endtask

    task automatic t_pwm();
        int highs;
        do_reset();
        wr(3'd0, 8'd1);
        wr(3'd1, 8'd2);
        wr(3'd2, 8'd0);
        wr(3'd3, 8'd4);
        chk("R7 oe in pwm", inv_oe, 1);
        step(5);
        chk("R6 a high at restart", out_a, 1);
        chk("R7 a_n complement", out_a_n, 0);
        chk("R6 b match wins at zero", out_b, 0);
        chk("R7 b_n complement", out_b_n, 1);
        chk("R4 flags pwm", flags, 7);
        highs = 0;
        for (int i = 0; i < 5; i++) begin
            step(1);
            if (out_a) highs++;
        end
        chk("R6 a duty 2 of 5", highs, 2);
        wr(3'd2, 8'd7);
        step(5);
        highs = 0;
        for (int i = 0; i < 5; i++) begin
            step(1);
            if (out_b) highs++;
        end
        chk("R6 b above top steady high", highs, 5);
        wr(3'd0, 8'd0);
        chk("R7 normal disables inverted", {out_a_n, out_b_n, inv_oe}, 0);
    endtask

    task automatic t_flags_irq();
        do_reset();
        wr(3'd3, 8'd2);
        wr(3'd1, 8'd1);
        wr(3'd2, 8'd9);
        step(3);
        chk("R9 masked irq low", irq, 0);
        chk("R8 flags present", flags, 3);
        wr(3'd4, 8'h04);
        chk("R9 mask other bit low", irq, 0);
        wr(3'd4, 8'h01);
        chk("R9 irq on ovf", irq, 1);
        wr(3'd5, 8'h02);
        chk("R8 clear one bit only", flags, 1);
        wr(3'd5, 8'h01);
        chk("R8 clear ovf", flags, 0);
        chk("R9 irq drops", irq, 0);
        step(2);
        cnt_en = 1'b1; wr_en = 1'b1; wr_addr = 3'd5; wr_data = 8'h01;
        tick();
        cnt_en = 1'b0; wr_en = 1'b0;
        chk("R8 set wins over clear", flags[0], 1);
        chk("R10 count after writes", count, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_top_wrap();
        t_top_below();
        t_normal();
        t_pwm();
        t_flags_irq();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule